// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address for 4 KiB pages. The page tables live in memory and have two levels. A request carries the linear address, a write flag and a user-mode flag. The block first checks a small, fully associative translation cache. On a miss it reads one directory entry and one table entry through a memory read port that uses a request/response handshake with variable latency.

The block applies the present, write and user permission rules across both levels. It returns either the physical address or a fault. A fault carries a three-bit error code, and the faulting linear address is captured in a register that stays readable afterwards. Only one request is in flight at a time. Software loads the physical address of the page directory through a write strobe, and every such write empties the translation cache.

Top module: `pt_walker`

## Requirements
- R1: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a byte offset (bits 11:0). The directory entry is read at base + 4*directory index. The table entry is read at {directory entry bits 31:12, table index, 2'b00}. A successful translation returns {table entry bits 31:12, byte offset}.
- R2: Bit 0 of an entry is the present bit. A clear present bit in the directory entry faults after exactly one memory read. A clear present bit in the table entry faults after two reads. In both cases error-code bit 0 is 0.
- R3: A user access (reqUser=1) is allowed only when bit 2 (user) is set in both the directory entry and the table entry. A supervisor access (reqUser=0) ignores bit 2.
- R4: A write (reqWrite=1) is refused in either mode when bit 1 (writable) is clear in either level.
- R5: The error code of a fault is {bit2 = reqUser, bit1 = reqWrite, bit0 = 1 for a protection violation and 0 for not-present}. rspErr is 0 and rspPhys is 0 as appropriate: on success rspErr is 0, and on a fault rspPhys is 0.
- R6: faultAddr resets to 0, takes the linear address of each faulting request in the same cycle that the fault response appears, and holds its value otherwise.
- R7: A translation cache hit produces rspValid one cycle after the request is accepted. It makes no memory read and applies the same R3/R4 checks, using the combined permissions stored at fill time.
- R8: Only walks that end without a fault fill the cache. A request whose walk faulted walks again on its next attempt.
- R9: The cache holds 4 entries. Fills replace entries in round-robin order, starting at entry 0 after reset or flush.
- R10: A pulse on baseWrEn loads the directory base (bits 31:12 of baseWrData) and invalidates every cache entry.
- R11: reqReady is high only when the block is idle. rspValid is a single-cycle pulse. memReqValid and memReqAddr hold until memReqReady.
- R12: During and after reset: reqReady=1, rspValid=0, memReqValid=0, faultAddr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block idle, request accepted when valid |
| reqAddr | input | 32 | Linear address |
| reqWrite | input | 1 | 1 = write access |
| reqUser | input | 1 | 1 = user-mode access |
| baseWrEn | input | 1 | Load directory base and flush cache |
| baseWrData | input | 32 | New directory base (bits 31:12 used) |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memReqAddr | output | 32 | Physical address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry read from memory |
| rspValid | output | 1 | One-cycle response pulse |
| rspFault | output | 1 | Response is a fault |
| rspPhys | output | 32 | Physical address on success |
| rspErr | output | 3 | Fault error code |
| faultAddr | output | 32 | Last faulting linear address |

## Verification
The assertions assume three things about the environment. Memory returns exactly one response for each accepted read and never raises memRspValid while no read is outstanding. baseWrEn is not pulsed while a walk is in flight. Requests are only offered in cycles when reqReady is high. The stimulus follows all three rules: the memory model serves one read at a time with a latency that rotates through 0 to 2 cycles, every base write happens between completed requests, and each new request is driven only after the previous response pulse.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = ADDR_W - OFF_W;
  localparam int PFN_W  = ADDR_W - OFF_W;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITE   = 1;
  localparam int BIT_USER    = 2;

  typedef struct packed {
    logic accept;
    logic latchPde;
    logic finishNp;
    logic finishWalk;
    logic finishHit;
    logic selPte;
  } walkStrobe_t;
endpackage

// File: rtl/walk_tlb.sv
module walk_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [VPN_W-1:0] lookVpn,
  input  logic             fillEn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillRw,
  input  logic             fillUs,
  output logic             hit,
  output logic [PFN_W-1:0] hitPfn,
  output logic             hitRw,
  output logic             hitUs
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hitVec;
  logic [VPN_W-1:0]   vpnArr [ENTRIES];
  logic [PFN_W-1:0]   pfnArr [ENTRIES];
  logic [ENTRIES-1:0] rwArr;
  logic [ENTRIES-1:0] usArr;
  logic [PTR_W-1:0]   victim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld    <= '0;
      victim <= '0;
    end else if (flush) begin
      vld    <= '0;
      victim <= '0;
    end else if (fillEn) begin
      vld[victim] <= 1'b1;
      victim <= (victim == PTR_W'(ENTRIES - 1)) ? '0 : victim + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn) begin
      vpnArr[victim] <= fillVpn;
      pfnArr[victim] <= fillPfn;
      rwArr[victim]  <= fillRw;
      usArr[victim]  <= fillUs;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gCmp
      assign hitVec[g] = vld[g] && (vpnArr[g] == lookVpn);
    end
  endgenerate

  always_comb begin
    hitPfn = '0;
    hitRw  = 1'b0;
    hitUs  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitPfn = hitPfn | pfnArr[i];
        hitRw  = hitRw | rwArr[i];
        hitUs  = hitUs | usArr[i];
      end
    end
  end
  assign hit = |hitVec;

  // R8
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R8
  fill_on_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillEn |-> !hit);
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        tlbHit,
  input  logic        rspPresent,
  output logic        memReqValid,
  input  logic        memReqReady,
  input  logic        memRspValid,
  output walkStrobe_t strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_PDE_RQ, S_PDE_WT, S_PTE_RQ, S_PTE_WT
  } walkState_t;

  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        strobe.accept = 1'b1;
        nextState     = S_LOOK;
      end
      S_LOOK: if (tlbHit) begin
        strobe.finishHit = 1'b1;
        nextState        = S_IDLE;
      end else begin
        nextState = S_PDE_RQ;
      end
      S_PDE_RQ: if (memReqReady) nextState = S_PDE_WT;
      S_PDE_WT: if (memRspValid) begin
        if (rspPresent) begin
          strobe.latchPde = 1'b1;
          nextState       = S_PTE_RQ;
        end else begin
          strobe.finishNp = 1'b1;
          nextState       = S_IDLE;
        end
      end
      S_PTE_RQ: begin
        strobe.selPte = 1'b1;
        if (memReqReady) nextState = S_PTE_WT;
      end
      S_PTE_WT: begin
        strobe.selPte = 1'b1;
        if (memRspValid) begin
          strobe.finishWalk = 1'b1;
          nextState         = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_PDE_RQ) || (state == S_PTE_RQ);

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/walk_dp.sv
module walk_dp
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic              baseWrEn,
  input  logic [ADDR_W-1:0] baseWrData,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspPresent,
  output logic [VPN_W-1:0]  lookVpn,
  input  logic              tlbHit,
  input  logic [PFN_W-1:0]  hitPfn,
  input  logic              hitRw,
  input  logic              hitUs,
  output logic              tlbFlush,
  output logic              fillEn,
  output logic [VPN_W-1:0]  fillVpn,
  output logic [PFN_W-1:0]  fillPfn,
  output logic              fillRw,
  output logic              fillUs,
  output logic              rspValid,
  output logic              rspFault,
  output logic [ADDR_W-1:0] rspPhys,
  output logic [2:0]        rspErr,
  output logic [ADDR_W-1:0] faultAddr
);
  logic [ADDR_W-1:0] curAddr;
  logic              curWrite, curUser;
  logic [PFN_W-1:0]  dirBase;
  logic [PFN_W-1:0]  pdeFrame;
  logic              pdeRw, pdeUs;
  logic              isFault, isProt, finishAny;
  logic [PFN_W-1:0]  okPfn;
  logic              combRw, combUs;
  logic              unusedDataBits;

  assign unusedDataBits = ^{memRspData[OFF_W-1:BIT_USER+1], baseWrData[OFF_W-1:0], tlbHit};

  function automatic logic violates(input logic rw, input logic us,
                                    input logic wr, input logic usr);
    return (usr && !us) || (wr && !rw);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirBase <= '0;
    end else if (baseWrEn) begin
      dirBase <= baseWrData[ADDR_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWrite <= 1'b0;
      curUser  <= 1'b0;
    end else if (strobe.accept) begin
      curAddr  <= reqAddr;
      curWrite <= reqWrite;
      curUser  <= reqUser;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdeFrame <= '0;
      pdeRw    <= 1'b0;
      pdeUs    <= 1'b0;
    end else if (strobe.latchPde) begin
      pdeFrame <= memRspData[ADDR_W-1:OFF_W];
      pdeRw    <= memRspData[BIT_WRITE];
      pdeUs    <= memRspData[BIT_USER];
    end
  end

  assign memReqAddr = strobe.selPte
    ? {pdeFrame, curAddr[OFF_W+IDX_W-1:OFF_W], 2'b00}
    : ({dirBase, {OFF_W{1'b0}}} + {{(ADDR_W-IDX_W-2){1'b0}}, curAddr[ADDR_W-1:ADDR_W-IDX_W], 2'b00});

  assign rspPresent = memRspData[BIT_PRESENT];
  assign lookVpn    = curAddr[ADDR_W-1:OFF_W];
  assign tlbFlush   = baseWrEn;

  assign combRw = pdeRw & memRspData[BIT_WRITE];
  assign combUs = pdeUs & memRspData[BIT_USER];

  always_comb begin
    isFault = 1'b0;
    isProt  = 1'b0;
    okPfn   = '0;
    if (strobe.finishHit) begin
      isProt  = violates(hitRw, hitUs, curWrite, curUser);
      isFault = isProt;
      okPfn   = hitPfn;
    end else if (strobe.finishNp) begin
      isFault = 1'b1;
    end else if (strobe.finishWalk) begin
      if (!memRspData[BIT_PRESENT]) begin
        isFault = 1'b1;
      end else begin
        isProt  = violates(combRw, combUs, curWrite, curUser);
        isFault = isProt;
        okPfn   = memRspData[ADDR_W-1:OFF_W];
      end
    end
  end

  assign finishAny = strobe.finishHit | strobe.finishNp | strobe.finishWalk;
  assign fillEn    = strobe.finishWalk && !isFault;
  assign fillVpn   = curAddr[ADDR_W-1:OFF_W];
  assign fillPfn   = memRspData[ADDR_W-1:OFF_W];
  assign fillRw    = combRw;
  assign fillUs    = combUs;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= 1'b0;
      rspPhys   <= '0;
      rspErr    <= '0;
      faultAddr <= '0;
    end else begin
      rspValid <= finishAny;
      if (finishAny) begin
        rspFault <= isFault;
        rspErr   <= isFault ? {curUser, curWrite, isProt} : 3'b000;
        rspPhys  <= isFault ? '0 : {okPfn, curAddr[OFF_W-1:0]};
        if (isFault) faultAddr <= curAddr;
      end
    end
  end

  // R6
  fault_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (faultAddr == curAddr));

  // R5
  err_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (rspErr[2] == curUser && rspErr[1] == curWrite));

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int TLB_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic        reqUser,
  input  logic        baseWrEn,
  input  logic [31:0] baseWrData,
  output logic        memReqValid,
  input  logic        memReqReady,
  output logic [31:0] memReqAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        rspValid,
  output logic        rspFault,
  output logic [31:0] rspPhys,
  output logic [2:0]  rspErr,
  output logic [31:0] faultAddr
);
  walkStrobe_t      strobe;
  logic             tlbHit, hitRw, hitUs, rspPresent;
  logic [PFN_W-1:0] hitPfn, fillPfn;
  logic [VPN_W-1:0] lookVpn, fillVpn;
  logic             tlbFlush, fillEn, fillRw, fillUs;

  walk_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .reqReady, .tlbHit, .rspPresent,
    .memReqValid, .memReqReady, .memRspValid, .strobe
  );

  walk_dp u_dp (
    .clk, .rstN, .strobe, .reqAddr, .reqWrite, .reqUser, .baseWrEn,
    .baseWrData, .memRspData, .memReqAddr, .rspPresent, .lookVpn,
    .tlbHit, .hitPfn, .hitRw, .hitUs, .tlbFlush, .fillEn, .fillVpn,
    .fillPfn, .fillRw, .fillUs, .rspValid, .rspFault, .rspPhys,
    .rspErr, .faultAddr
  );

  walk_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
    .clk, .rstN, .flush(tlbFlush), .lookVpn, .fillEn, .fillVpn,
    .fillPfn, .fillRw, .fillUs, .hit(tlbHit), .hitPfn, .hitRw, .hitUs
  );

  // R11
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));
endmodule

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqUser = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        baseWrEn = 1'b0;
  logic [31:0] baseWrData = '0;
  logic        memReqReady = 1'b0, memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        reqReady, memReqValid, rspValid, rspFault;
  logic [31:0] memReqAddr, rspPhys, faultAddr;
  logic [2:0]  rspErr;

  int checks = 0, errors = 0, cycles = 0, reads = 0;
  logic [31:0] addrPrev = '0, addrLast = '0;
  logic [31:0] mem [0:4095];

  always #2 clk = ~clk;

  pt_walker u0 (.*);

  typedef struct packed {
    logic [31:0] a; logic w; logic u; logic f; logic [2:0] e; logic [31:0] p; logic [1:0] rd;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{32'h00400123, 1'b0, 1'b1, 1'b0, 3'd0, 32'hAAAAA123, 2'd2},
    '{32'h00401FFC, 1'b1, 1'b1, 1'b1, 3'd7, 32'h0,        2'd2},
    '{32'h00401008, 1'b0, 1'b1, 1'b0, 3'd0, 32'hBBBBB008, 2'd2},
    '{32'h00402010, 1'b0, 1'b1, 1'b1, 3'd5, 32'h0,        2'd2},
    '{32'h00402010, 1'b1, 1'b0, 1'b0, 3'd0, 32'hCCCCC010, 2'd2},
    '{32'h00403000, 1'b0, 1'b0, 1'b1, 3'd0, 32'h0,        2'd2},
    '{32'h00000ABC, 1'b1, 1'b1, 1'b1, 3'd6, 32'h0,        2'd1},
    '{32'h00800044, 1'b1, 1'b0, 1'b1, 3'd3, 32'h0,        2'd2},
    '{32'h00800044, 1'b0, 1'b1, 1'b1, 3'd5, 32'h0,        2'd2},
    '{32'h00800044, 1'b0, 1'b0, 1'b0, 3'd0, 32'h12345044, 2'd2},
    '{32'h00400123, 1'b1, 1'b1, 1'b0, 3'd0, 32'hAAAAA123, 2'd0},
    '{32'h00401008, 1'b1, 1'b1, 1'b1, 3'd7, 32'h0,        2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one read at a time, latency rotates 0..2
  initial begin
    int lat = 0;
    forever begin
      @(negedge clk);
      if (memReqValid) begin
        memReqReady = 1'b1;
        addrPrev = addrLast;
        addrLast = memReqAddr;
        reads++;
        @(negedge clk);
        memReqReady = 1'b0;
        repeat (lat) @(negedge clk);
        memRspData  = mem[addrLast[13:2]];
        memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
        lat = (lat + 1) % 3;
      end
    end
  end

  task automatic runReq(input logic [31:0] a, input logic w, input logic u,
                        output logic f, output logic [31:0] p, output logic [2:0] e,
                        output int lat, output int rd, output logic busy);
    int r0;
    @(negedge clk);
    reqAddr = a; reqWrite = w; reqUser = u; reqValid = 1'b1;
    r0 = reads;
    @(negedge clk);
    reqValid = 1'b0;
    busy = !reqReady;
    lat = 0;
    while (!rspValid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    if (lat >= 200) chk(1'b0, "R11 response timeout", 32'(lat), 32'd0);
    f = rspFault; p = rspPhys; e = rspErr; rd = reads - r0;
  endtask

  task automatic setBase(input logic [31:0] b);
    @(negedge clk);
    baseWrData = b; baseWrEn = 1'b1;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        chk(1'b0, "watchdog", 32'(cycles), 32'd100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic f, busy;
    logic [31:0] p, lastFault;
    logic [2:0] e;
    int lat, rd;

    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[1]    = 32'h00001007;
    mem[2]    = 32'h00002001;
    mem[1024] = 32'hAAAAA007;
    mem[1025] = 32'hBBBBB005;
    mem[1026] = 32'hCCCCC003;
    mem[1027] = 32'hDDDDD006;
    mem[1028] = 32'hEEEEE007;
    mem[2048] = 32'h12345007;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk(reqReady == 1'b1, "R12 reqReady", 32'(reqReady), 32'd1);
    chk(rspValid == 1'b0, "R12 rspValid", 32'(rspValid), 32'd0);
    chk(memReqValid == 1'b0, "R12 memReqValid", 32'(memReqValid), 32'd0);
    chk(faultAddr == 32'h0, "R12 faultAddr", faultAddr, 32'h0);
    rstN = 1'b1;
    setBase(32'h00004000);
    lastFault = 32'h0;

    for (int i = 0; i < 12; i++) begin
      runReq(VECS[i].a, VECS[i].w, VECS[i].u, f, p, e, lat, rd, busy);
      chk(f == VECS[i].f, "R3/R4 fault flag", 32'(f), 32'(VECS[i].f));
      chk(e == VECS[i].e, "R5 error code", 32'(e), 32'(VECS[i].e));
      if (!VECS[i].f) chk(p == VECS[i].p, "R1 physical address", p, VECS[i].p);
      chk(rd == int'(VECS[i].rd), "R2/R7 memory reads", 32'(rd), 32'(VECS[i].rd));
      if (VECS[i].f) lastFault = VECS[i].a;
      chk(faultAddr == lastFault, "R6 faultAddr", faultAddr, lastFault);
      chk(busy, "R11 reqReady low while busy", 32'(busy), 32'd1);
      @(negedge clk);
      chk(!rspValid, "R11 single pulse", 32'(rspValid), 32'd0);
    end

    // R7 hit latency and no memory access
    runReq(32'h00402010, 1'b0, 1'b0, f, p, e, lat, rd, busy);
    chk(lat == 1, "R7 hit latency", 32'(lat), 32'd1);
    chk(rd == 0, "R7 hit reads", 32'(rd), 32'd0);
    chk(p == 32'hCCCCC010, "R7 hit phys", p, 32'hCCCCC010);

    // R8 faulting walk is not cached
    runReq(32'h00403000, 1'b0, 1'b0, f, p, e, lat, rd, busy);
    chk(rd == 2, "R8 repeat walk after fault", 32'(rd), 32'd2);
    chk(faultAddr == 32'h00403000, "R6 faultAddr held", faultAddr, 32'h00403000);

    // R1 entry addresses; this fill replaces entry 0 (R9)
    runReq(32'h00404ABC, 1'b0, 1'b1, f, p, e, lat, rd, busy);
    chk(addrPrev == 32'h00004004, "R1 directory entry address", addrPrev, 32'h00004004);
    chk(addrLast == 32'h00001010, "R1 table entry address", addrLast, 32'h00001010);
    chk(p == 32'hEEEEEABC, "R1 physical address", p, 32'hEEEEEABC);

    // R9 round-robin
    runReq(32'h00401008, 1'b0, 1'b1, f, p, e, lat, rd, busy);
    chk(rd == 0, "R9 entry 1 still cached", 32'(rd), 32'd0);
    runReq(32'h00400123, 1'b0, 1'b1, f, p, e, lat, rd, busy);
    chk(rd == 2, "R9 entry 0 evicted", 32'(rd), 32'd2);
    runReq(32'h00401008, 1'b0, 1'b1, f, p, e, lat, rd, busy);
    chk(rd == 2, "R9 entry 1 evicted next", 32'(rd), 32'd2);

    // R10 base write flushes and moves the directory
    setBase(32'h00008000);
    runReq(32'h00402010, 1'b1, 1'b0, f, p, e, lat, rd, busy);
    chk(rd == 2, "R10 flushed cache walks", 32'(rd), 32'd2);
    chk(addrPrev == 32'h00008004, "R10 new base used", addrPrev, 32'h00008004);
    chk(p == 32'hCCCCC010, "R10 phys after flush", p, 32'hCCCCC010);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule